// File: doc/BRIEF.md
# Negatable-Operand Integer ALU

This block is a purely combinational integer arithmetic and logic unit. It takes two operands and a three-bit control word and returns a result of the operand width together with a flag that marks an all-zero result. The control word is made of an invert bit for the second operand (the most significant control bit) and a two-bit selector that picks among a bitwise AND, a bitwise OR, the adder sum and a signed less-than flag.

Subtraction and the signed compare share the single adder. When the invert bit is set, every bit of the second operand is complemented and the adder carry-in is forced to one, so the adder forms A minus B. The less-than flag is the sign of that sum corrected by the signed overflow term, which keeps the compare right for operands of opposite sign. All eight control codes give a defined result, including the three that are not among the five named operations. The operand width and the adder structure (a bit-level ripple chain or a single wide add) are parameters.

Top module: `alu_core`

## Requirements
- R1: Control code 000 (invert bit 0, selector 00) drives the result to the bitwise AND of A and B.
- R2: Control code 001 drives the result to the bitwise OR of A and B.
- R3: Control code 010 drives the result to A plus B, kept modulo two to the power of the width.
- R4: Control code 110 drives the result to A minus B, kept modulo two to the power of the width.
- R5: Control code 111 drives bit 0 of the result to 1 when A is less than B as two's complement numbers, and to 0 otherwise; all bits above bit 0 are zero, including when A and B have opposite signs.
- R6: Control codes 100 and 101 drive the result to A AND (NOT B) and to A OR (NOT B) respectively.
- R7: Control code 011 drives bit 0 of the result to 1 exactly when the exact (unwrapped) two's complement sum A plus B is negative, with all upper bits zero.
- R8: The zero output is 1 exactly when every bit of the result is 0, for every control code.
- R9: The behaviour of R1 to R8 holds at any operand width of two or more and for both adder structures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, complemented when ctrl[2] is set |
| ctrl | input | 3 | Bit 2 inverts B and sets adder carry-in; bits 1:0 select AND, OR, sum, less-than |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when result is all zero |

## Verification
Since the block holds no state, a wrong internal value appears at the result port in the same evaluation as the inputs that provoke it: a broken carry stage or a miswired invert shows as a wrong sum for particular operand pairs, and a missing overflow correction shows only when the operands differ in sign near the range limits. The four-bit instances are swept over every operand pair and every control code for both adder structures, so every such fault surfaces; the full-width instance is driven with boundary values and pseudo-random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_SUM  = 2'b10,
      SEL_LESS = 2'b11
   } alu_sel_e;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_WIDE   = 1;

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] and_out,
   output logic [WIDTH-1:0] or_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("alu_logic_unit: WIDTH must be positive");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign and_out[i] = a[i] & b[i];
      assign or_out[i]  = a[i] | b[i];
   end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = alu_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             ovf
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_adder: WIDTH must be at least 2");
   end
   if (STYLE != alu_pkg::ADDER_RIPPLE && STYLE != alu_pkg::ADDER_WIDE) begin : g_bad_style
      $error("alu_adder: unknown STYLE");
   end

   if (STYLE == alu_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH:0] carry;
      assign carry[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_fa
         logic half;
         assign half       = a[i] ^ b[i];
         assign sum[i]     = half ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & half);
      end
      assign ovf = carry[WIDTH] ^ carry[WIDTH-1];
   end else begin : g_wide
      logic [WIDTH:0] ext;
      logic           msb_cin;
      assign ext     = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      assign sum     = ext[WIDTH-1:0];
      assign msb_cin = a[WIDTH-1] ^ b[WIDTH-1] ^ ext[WIDTH-1];
      assign ovf     = ext[WIDTH] ^ msb_cin;
   end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] value,
   output logic             is_zero
);

   if (WIDTH < 1) begin : g_bad_width
      $error("alu_zero_detect: WIDTH must be positive");
   end

   logic [WIDTH:0] any_set;
   assign any_set[0] = 1'b0;
   for (genvar i = 0; i < WIDTH; i++) begin : g_scan
      assign any_set[i+1] = any_set[i] | value[i];
   end
   assign is_zero = ~any_set[WIDTH];

endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = alu_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       ctrl,
   output logic [WIDTH-1:0] result,
   output logic             zero
);
   import alu_pkg::*;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end

   logic             invert_b;
   alu_sel_e         sel;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] and_val;
   logic [WIDTH-1:0] or_val;
   logic [WIDTH-1:0] sum_val;
   logic             ovf;
   logic             less;

   assign invert_b = ctrl[2];
   assign sel      = alu_sel_e'(ctrl[1:0]);
   assign b_eff    = invert_b ? ~opnd_b : opnd_b;

   alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a       (opnd_a),
      .b       (b_eff),
      .and_out (and_val),
      .or_out  (or_val)
   );

   alu_adder #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_adder (
      .a   (opnd_a),
      .b   (b_eff),
      .cin (invert_b),
      .sum (sum_val),
      .ovf (ovf)
   );

   // Sign of the sum, flipped when the signed add overflowed.
   assign less = sum_val[WIDTH-1] ^ ovf;

   always_comb begin
      unique case (sel)
         SEL_AND:  result = and_val;
         SEL_OR:   result = or_val;
         SEL_SUM:  result = sum_val;
         SEL_LESS: result = {{(WIDTH-1){1'b0}}, less};
         default:  result = '0;
      endcase
   end

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .value   (result),
      .is_zero (zero)
   );

   always_comb begin
      if (ctrl == 3'b000) begin
         assert_and_subset_R1: assert (((result | opnd_a) == opnd_a) && ((result | opnd_b) == opnd_b));
      end
      if (ctrl == 3'b001) begin
         assert_or_superset_R2: assert (((result & opnd_a) == opnd_a) && ((result & opnd_b) == opnd_b));
      end
      if (ctrl == 3'b010) begin
         assert_add_inverse_R3: assert ((result - opnd_b) == opnd_a);
      end
      if (ctrl == 3'b110) begin
         assert_sub_inverse_R4: assert ((result + opnd_b) == opnd_a);
      end
      if (ctrl[1:0] == 2'b11) begin
         assert_flag_upper_clear_R5: assert (result[WIDTH-1:1] == '0);
      end
      if (ctrl == 3'b111 && opnd_a[WIDTH-1] != opnd_b[WIDTH-1]) begin
         assert_sign_split_R5: assert (result[0] == opnd_a[WIDTH-1]);
      end
      assert_zero_flag_R8: assert (zero == (result == '0));
   end

endmodule

// File: tb/sim_alu_core.sv
module sim_alu_core;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;   // 250 MHz

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] a32, b32, r32;
   logic [2:0]  c32;
   logic        z32;
   logic [3:0]  a4, b4, r4r, r4w;
   logic [2:0]  c4;
   logic        z4r, z4w;

   alu_core u0 (.opnd_a(a32), .opnd_b(b32), .ctrl(c32), .result(r32), .zero(z32));
   alu_core #(.WIDTH(4), .ADDER_STYLE(alu_pkg::ADDER_RIPPLE)) u1 (
      .opnd_a(a4), .opnd_b(b4), .ctrl(c4), .result(r4r), .zero(z4r));
   alu_core #(.WIDTH(4), .ADDER_STYLE(alu_pkg::ADDER_WIDE)) u2 (
      .opnd_a(a4), .opnd_b(b4), .ctrl(c4), .result(r4w), .zero(z4w));

   function automatic string req_of(input logic [2:0] c);
      case (c)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b110: return "R4";
         3'b111: return "R5";
         3'b011: return "R7";
         default: return "R6";
      endcase
   endfunction

   // Arithmetic model for any width up to 32.
   function automatic logic [63:0] model(input int w, input logic [63:0] a,
                                         input logic [63:0] b, input logic [2:0] c);
      logic [63:0] mask = (64'd1 << w) - 64'd1;
      logic [63:0] bx = c[2] ? (~b & mask) : (b & mask);
      longint sa, sb, s;
      sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
      sb = bx[w-1] ? longint'(bx) - (longint'(1) << w) : longint'(bx);
      case (c[1:0])
         2'b00: return a & bx;
         2'b01: return a | bx;
         2'b10: return (a + bx + {63'd0, c[2]}) & mask;
         default: begin
            s = sa + sb + longint'(c[2]);
            return (s < 0) ? 64'd1 : 64'd0;
         end
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] c);
      logic [63:0] e;
      @(posedge clk);
      a32 = a; b32 = b; c32 = c;
      #1;
      e = model(32, {32'd0, a}, {32'd0, b}, c);
      check({req_of(c), " w32"}, {32'd0, r32}, e);
      check("R8 w32", {63'd0, z32}, {63'd0, e == 64'd0});
   endtask

   initial begin
      a32 = '0; b32 = '0; c32 = '0; a4 = '0; b4 = '0; c4 = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      #1;
      check("R1 idle", {32'd0, r32}, 64'd0);
      check("R8 idle", {63'd0, z32}, 64'd1);

      // R9: exhaustive sweep at width 4, both adder structures.
      for (int c = 0; c < 8; c++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               logic [63:0] e;
               @(posedge clk);
               a4 = 4'(a); b4 = 4'(b); c4 = 3'(c);
               #1;
               e = model(4, 64'(a), 64'(b), 3'(c));
               check({req_of(3'(c)), " R9 ripple"}, {60'd0, r4r}, e);
               check({req_of(3'(c)), " R9 wide"}, {60'd0, r4w}, e);
               check("R8 R9 ripple", {63'd0, z4r}, {63'd0, e == 64'd0});
               check("R8 R9 wide", {63'd0, z4w}, {63'd0, e == 64'd0});
            end
         end
      end

      // Full-width boundary operands.
      begin
         logic [31:0] corner [8];
         corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
         corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
         corner[4] = 32'h8000_0000; corner[5] = 32'h8000_0001;
         corner[6] = 32'h5555_5555; corner[7] = 32'hAAAA_AAAA;
         for (int c = 0; c < 8; c++)
            for (int i = 0; i < 8; i++)
               for (int j = 0; j < 8; j++)
                  run32(corner[i], corner[j], 3'(c));
      end

      // Directed: R5 across the sign boundary, R4 equal operands give zero.
      run32(32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
      check("R5 min<max", {32'd0, r32}, 64'd1);
      run32(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
      check("R5 max<min", {32'd0, r32}, 64'd0);
      run32(32'h1234_5678, 32'h1234_5678, 3'b110);
      check("R8 sub equal", {63'd0, z32}, 64'd1);

      // Pseudo-random full-width operands.
      begin
         logic [31:0] x = 32'h1ACE_B00C;
         logic [31:0] y = 32'hDEAD_2468;
         for (int n = 0; n < 400; n++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
            for (int c = 0; c < 8; c++) run32(x, y, 3'(c));
         end
      end

      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 150000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule